// File: doc/BRIEF.md
# Memory Attribute Request Router

This block sits between a load/store unit and the memory hierarchy. It takes each request together with its page attributes: memory type, inner and outer cacheability, and shareability. It then decides where the request goes. Normal Write-Back requests go to the cache lookup path, with a flag that says whether a miss may allocate a line. All other requests skip every cache and go straight to the external bus as a no-snoop transaction. Such a bypass request carries a write/read bit, an ordered-device bit, a system-shareable flag and the outer attribute it is sent with.

A fixed remapping is built into the steering. Write-Through pages are never looked up. Shared pages whose inner attribute is Write-Through or Non-Cacheable are sent out as outer Non-Cacheable, system-shareable no-snoop traffic. Device and Strongly-ordered requests are treated alike whatever their shareability. The decision is held in one output register. Each accepted request appears exactly once on one of the two paths, one cycle after acceptance. A stalled path holds the input handshake, so requests are neither dropped nor reordered.

Encodings: memory type 0 = Normal, 1 = Device, 2 = Strongly-ordered, 3 = reserved (handled as Strongly-ordered). Cacheability 0 = Non-Cacheable (NC), 1 = Write-Through (WT), 2 = Write-Back allocate, 3 = Write-Back no-allocate. Shareability bit 0 = inner shared, bit 1 = outer shared.

Top module: `mem_attr_router`

## Requirements
- R1: A Normal request with inner cacheability 2 or 3 appears on the cache path, and only there, in the cycle after it is accepted. It carries the same address and write bit. For inner cacheability 2, cch_alloc is 1.
- R2: A Normal request with inner cacheability 3 (Write-Back no-allocate) goes to the cache path with cch_alloc = 0.
- R3: On the cache path, cch_coherent equals the inner-shared bit (in_shr[0]) of the request, whatever its allocation hint.
- R4: A Normal request with inner cacheability 1 (Write-Through) never reaches the cache path. It appears on the bypass path one cycle after acceptance.
- R5: A Normal request with inner cacheability 0 (Non-Cacheable) appears on the bypass path and never on the cache path.
- R6: A Normal bypass request with either shareability bit set has byp_shared = 1 and byp_outer = 0 (NC). A Normal bypass request with both shareability bits clear has byp_shared = 0 and byp_outer equal to in_ocache.
- R7: byp_kind bit 0 is the write bit of the request. Bit 1 is 1 for memory types 1, 2 and 3 and 0 for Normal. So a Normal read is kind 0 (read no-snoop) and a Normal write is kind 1 (write no-snoop).
- R8: Device, Strongly-ordered and reserved requests always bypass with byp_shared = 0 and byp_outer = 0, whatever in_shr and in_ocache hold.
- R9: While the held output's path has its ready low, in_ready is 0 and the held output stays unchanged. Every accepted request is delivered exactly once, in acceptance order.
- R10: After reset, cch_valid and byp_valid are 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted this cycle when high with in_valid |
| in_addr | input | ADDR_W | Request address |
| in_write | input | 1 | 1 = store, 0 = load |
| in_mtype | input | 2 | Memory type |
| in_icache | input | 2 | Inner cacheability |
| in_ocache | input | 2 | Outer cacheability |
| in_shr | input | 2 | Shareability, bit 0 inner, bit 1 outer |
| cch_valid | output | 1 | Cache-path request valid |
| cch_ready | input | 1 | Cache path can take the request |
| cch_addr | output | ADDR_W | Cache-path address |
| cch_write | output | 1 | Cache-path write bit |
| cch_alloc | output | 1 | Allocate a line on miss |
| cch_coherent | output | 1 | Request belongs to the inner coherent domain |
| byp_valid | output | 1 | Bypass bus request valid |
| byp_ready | input | 1 | Bus can take the bypass request |
| byp_addr | output | ADDR_W | Bypass address |
| byp_kind | output | 2 | Bit 0 write, bit 1 ordered device access |
| byp_shared | output | 1 | System-shareable no-snoop transaction |
| byp_outer | output | 2 | Outer cacheability sent with the request |

## Verification
The bench targets four kinds of error. First, shared Write-Through and Non-Cacheable pages must be demoted; a router that forgot this would send a stale outer attribute or a clear shareable flag on the bus. Second, a Device request with shareability bits set must still look exactly like a non-shared one. Third, a Write-Back no-allocate request must not have its allocate flag copied from the allocating case. Fourth, the two readies are toggled at random while one request is held, to catch a router that lets a new request overwrite a stalled output, sends a request twice, or looks at the wrong path's ready.

// File: rtl/mar_pkg.sv
package mar_pkg;

   typedef enum logic [1:0] {
      MT_NORMAL = 2'd0,
      MT_DEVICE = 2'd1,
      MT_STRONG = 2'd2,
      MT_RSVD   = 2'd3
   } mtype_e;

   typedef enum logic [1:0] {
      CA_NC    = 2'd0,
      CA_WT    = 2'd1,
      CA_WB_RA = 2'd2,
      CA_WB_NA = 2'd3
   } cache_e;

   localparam int unsigned NPATH    = 2;
   localparam int unsigned PATH_CCH = 0;
   localparam int unsigned PATH_BYP = 1;

   typedef struct packed {
      logic       to_cache;
      logic       alloc;
      logic       coherent;
      logic [1:0] kind;
      logic       sys_shr;
      logic [1:0] outer;
   } route_t;

endpackage

// File: rtl/mar_classify.sv
module mar_classify
   import mar_pkg::*;
(
   input  logic       write,
   input  logic [1:0] mtype,
   input  logic [1:0] icache,
   input  logic [1:0] ocache,
   input  logic [1:0] shr,
   output route_t     route
);
   mtype_e mt;
   cache_e ic;
   logic   ordered;
   logic   any_shr;
   logic   inner_wb;

   always_comb begin
      mt       = mtype_e'(mtype);
      ic       = cache_e'(icache);
      ordered  = (mt != MT_NORMAL);
      any_shr  = |shr;
      inner_wb = (ic == CA_WB_RA) || (ic == CA_WB_NA);

      route          = '0;
      route.to_cache = !ordered && inner_wb;
      route.alloc    = route.to_cache && (ic == CA_WB_RA);
      route.coherent = route.to_cache && shr[0];
      route.kind     = {ordered, write};
      // device types ignore shareability; shared normal pages are demoted
      route.sys_shr  = !ordered && any_shr;
      route.outer    = (ordered || any_shr) ? CA_NC : ocache;
   end
endmodule

// File: rtl/mar_out_stage.sv
module mar_out_stage
   import mar_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic              in_write,
   input  route_t            in_route,
   input  logic [NPATH-1:0]  path_ready,
   output logic [NPATH-1:0]  path_valid,
   output logic [ADDR_W-1:0] q_addr,
   output logic              q_write,
   output route_t            q_route
);
   logic full;
   logic sel_ready;
   logic [NPATH-1:0] path_sel;

   assign path_sel[PATH_CCH] = q_route.to_cache;
   assign path_sel[PATH_BYP] = !q_route.to_cache;

   generate
      for (genvar p = 0; p < NPATH; p++) begin : g_path
         assign path_valid[p] = full && path_sel[p];
      end
   endgenerate

   assign sel_ready = |(path_sel & path_ready);
   assign in_ready  = !full || sel_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full    <= 1'b0;
         q_addr  <= '0;
         q_write <= 1'b0;
         q_route <= '0;
      end else if (in_ready) begin
         full <= in_valid;
         if (in_valid) begin
            q_addr  <= in_addr;
            q_write <= in_write;
            q_route <= in_route;
         end
      end
   end
endmodule

// File: rtl/mem_attr_router.sv
module mem_attr_router
   import mar_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic              in_write,
   input  logic [1:0]        in_mtype,
   input  logic [1:0]        in_icache,
   input  logic [1:0]        in_ocache,
   input  logic [1:0]        in_shr,
   output logic              cch_valid,
   input  logic              cch_ready,
   output logic [ADDR_W-1:0] cch_addr,
   output logic              cch_write,
   output logic              cch_alloc,
   output logic              cch_coherent,
   output logic              byp_valid,
   input  logic              byp_ready,
   output logic [ADDR_W-1:0] byp_addr,
   output logic [1:0]        byp_kind,
   output logic              byp_shared,
   output logic [1:0]        byp_outer
);
   generate
      if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_addr_w
         $error("mem_attr_router: ADDR_W must lie in 8..64");
      end
   endgenerate

   route_t            cls_route;
   route_t            q_route;
   logic [ADDR_W-1:0] q_addr;
   logic              q_write;
   logic [NPATH-1:0]  pv;
   logic [NPATH-1:0]  pr;

   mar_classify u_cls (
      .write  (in_write),
      .mtype  (in_mtype),
      .icache (in_icache),
      .ocache (in_ocache),
      .shr    (in_shr),
      .route  (cls_route)
   );

   assign pr[PATH_CCH] = cch_ready;
   assign pr[PATH_BYP] = byp_ready;

   mar_out_stage #(.ADDR_W(ADDR_W)) u_stage (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .in_addr    (in_addr),
      .in_write   (in_write),
      .in_route   (cls_route),
      .path_ready (pr),
      .path_valid (pv),
      .q_addr     (q_addr),
      .q_write    (q_write),
      .q_route    (q_route)
   );

   assign cch_valid    = pv[PATH_CCH];
   assign cch_addr     = q_addr;
   assign cch_write    = q_write;
   assign cch_alloc    = q_route.alloc;
   assign cch_coherent = q_route.coherent;

   assign byp_valid  = pv[PATH_BYP];
   assign byp_addr   = q_addr;
   assign byp_kind   = q_route.kind;
   assign byp_shared = q_route.sys_shr;
   assign byp_outer  = q_route.outer;
endmodule

// File: rtl/mar_chk.sv
module mar_chk #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [ADDR_W-1:0] in_addr,
   input logic              in_write,
   input logic [1:0]        in_mtype,
   input logic [1:0]        in_icache,
   input logic [1:0]        in_shr,
   input logic              cch_valid,
   input logic              cch_ready,
   input logic [ADDR_W-1:0] cch_addr,
   input logic              cch_write,
   input logic              byp_valid,
   input logic              byp_ready,
   input logic [ADDR_W-1:0] byp_addr,
   input logic [1:0]        byp_kind,
   input logic              byp_shared,
   input logic [1:0]        byp_outer
);
   p_one_path_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(cch_valid && byp_valid));

   p_accept_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (cch_valid || byp_valid));

   p_wt_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_mtype == 2'd0 && in_icache == 2'd1) |=> byp_valid);

   p_demote_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (byp_valid && byp_shared) |-> (byp_outer == 2'd0 && !byp_kind[1]));

   p_dev_plain_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (byp_valid && byp_kind[1]) |-> (!byp_shared && byp_outer == 2'd0));

   p_cch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cch_valid && !cch_ready) |=> (cch_valid && $stable(cch_addr) && $stable(cch_write)));

   p_byp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (byp_valid && !byp_ready) |=> (byp_valid && $stable(byp_addr) && $stable(byp_kind)));

   p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((cch_valid && !cch_ready) || (byp_valid && !byp_ready)) |-> !in_ready);
endmodule

bind mem_attr_router mar_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .in_addr    (in_addr),
   .in_write   (in_write),
   .in_mtype   (in_mtype),
   .in_icache  (in_icache),
   .in_shr     (in_shr),
   .cch_valid  (cch_valid),
   .cch_ready  (cch_ready),
   .cch_addr   (cch_addr),
   .cch_write  (cch_write),
   .byp_valid  (byp_valid),
   .byp_ready  (byp_ready),
   .byp_addr   (byp_addr),
   .byp_kind   (byp_kind),
   .byp_shared (byp_shared),
   .byp_outer  (byp_outer)
);

// File: tb/sim_mem_attr_router.sv
module sim_mem_attr_router;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [AW-1:0] in_addr = '0;
   logic          in_write = 1'b0;
   logic [1:0]    in_mtype = '0, in_icache = '0, in_ocache = '0, in_shr = '0;
   logic          cch_valid, cch_ready = 1'b1;
   logic [AW-1:0] cch_addr;
   logic          cch_write, cch_alloc, cch_coherent;
   logic          byp_valid, byp_ready = 1'b1;
   logic [AW-1:0] byp_addr;
   logic [1:0]    byp_kind, byp_outer;
   logic          byp_shared;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   mem_attr_router #(.ADDR_W(AW)) u0 (.*);

   typedef struct {
      bit          cache;
      logic [AW-1:0] addr;
      bit          wr;
      bit          alloc;
      bit          coh;
      logic [1:0]  kind;
      bit          shr;
      logic [1:0]  outer;
      logic [1:0]  mt;
      logic [1:0]  ic;
   } exp_t;

   exp_t exp_q[$];

   function automatic exp_t model(logic [AW-1:0] a, bit w, logic [1:0] mt,
                                  logic [1:0] ic, logic [1:0] oc, logic [1:0] sh);
      exp_t e;
      e.addr = a; e.wr = w; e.mt = mt; e.ic = ic;
      e.cache = 0; e.alloc = 0; e.coh = 0; e.kind = 2'b00; e.shr = 0; e.outer = 2'b00;
      if (mt != 2'd0) begin
         e.kind = {1'b1, w};
      end else if (ic >= 2'd2) begin
         e.cache = 1;
         e.alloc = (ic == 2'd2);
         e.coh   = sh[0];
      end else begin
         e.kind = {1'b0, w};
         if (sh != 2'b00) e.shr = 1;
         else e.outer = oc;
      end
      return e;
   endfunction

   task automatic chk(bit ok, string tag, longint act, longint expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, expv, $time);
      end
   endtask

   function automatic string byp_tag(exp_t e);
      if (e.mt != 2'd0) return "R8";
      if (e.ic == 2'd1) return "R4";
      return "R5";
   endfunction

   initial begin : watchdog
      #(1_500_000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      bit   rdy_exp;
      exp_t h;
      #12;
      chk(!cch_valid, "R10 cch_valid", cch_valid, 0);
      chk(!byp_valid, "R10 byp_valid", byp_valid, 0);
      chk(in_ready,  "R10 in_ready", in_ready, 1);
      @(negedge clk);
      rst_n = 1'b1;
      for (int cyc = 0; cyc < 4000; cyc++) begin
         @(negedge clk);
         in_valid  = ($urandom_range(0, 3) != 0);
         in_addr   = $urandom();
         in_write  = $urandom_range(0, 1);
         in_mtype  = $urandom_range(0, 3);
         if ($urandom_range(0, 1)) in_mtype = 2'd0;
         in_icache = $urandom_range(0, 3);
         in_ocache = $urandom_range(0, 3);
         in_shr    = $urandom_range(0, 3);
         if (cyc < 1000) begin
            cch_ready = 1'b1; byp_ready = 1'b1;
         end else begin
            cch_ready = ($urandom_range(0, 2) != 0);
            byp_ready = ($urandom_range(0, 2) != 0);
         end
         #1;
         if (exp_q.size() == 0) rdy_exp = 1;
         else rdy_exp = exp_q[0].cache ? cch_ready : byp_ready;
         chk(in_ready == rdy_exp, "R9 in_ready", in_ready, rdy_exp);
         if (exp_q.size() == 0) begin
            chk(!cch_valid && !byp_valid, "R9 no spurious output",
                {cch_valid, byp_valid}, 0);
         end else begin
            h = exp_q[0];
            if (h.cache) begin
               chk(cch_valid && !byp_valid, h.alloc ? "R1 cache path" : "R2 cache path",
                   {cch_valid, byp_valid}, 2'b10);
               chk(cch_addr == h.addr && cch_write == h.wr, "R1 addr/write",
                   {cch_addr, cch_write}, {h.addr, h.wr});
               chk(cch_alloc == h.alloc, h.alloc ? "R1 alloc" : "R2 alloc",
                   cch_alloc, h.alloc);
               chk(cch_coherent == h.coh, "R3 coherent", cch_coherent, h.coh);
            end else begin
               chk(byp_valid && !cch_valid, byp_tag(h), {cch_valid, byp_valid}, 2'b01);
               chk(byp_addr == h.addr, "R4 byp addr", byp_addr, h.addr);
               chk(byp_kind == h.kind, "R7 kind", byp_kind, h.kind);
               chk(byp_shared == h.shr && byp_outer == h.outer,
                   (h.mt != 2'd0) ? "R8 shared/outer" : "R6 shared/outer",
                   {byp_shared, byp_outer}, {h.shr, h.outer});
            end
         end
         @(posedge clk);
         if (exp_q.size() != 0 && (exp_q[0].cache ? cch_ready : byp_ready))
            void'(exp_q.pop_front());
         if (in_valid && rdy_exp)
            exp_q.push_back(model(in_addr, in_write, in_mtype, in_icache, in_ocache, in_shr));
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule